// File: doc/BRIEF.md
# Slope-Mode Density-Ramp PWM Generator

This block drives one low-resistance actuator output with a fixed pulse pattern. A series inductor and the capacitive load of a piezo element filter the pattern into a rhombic waveform with controlled edges. One waveform period follows this order: a rising ramp, a pad tick, a high plateau, a falling ramp, a pad tick and a low plateau. On the rising ramp the pulse density climbs one step per segment until it is full. The falling ramp steps it back down. The ramp size X is picked from four values. The period length, counted in base-unit ticks, sets how much time is left for the two plateaus.

The block advances one position per base tick. After a start, periods repeat for as long as the enable input stays high. The period length and the ramp select are sampled afresh at the start of every period, so they can be changed on the fly without tearing a period. If a period value is too short to hold both ramps, the plateaus collapse to zero and an error flag is raised for that period.

Top module: `slope_pwm`

## Requirements
- R1: After reset, pwm_out, running and cfg_err are all 0.
- R2: While enable is low, pwm_out, running and cfg_err are 0 in the cycle after enable is sampled low, and start has no effect.
- R3: A start pulse in the idle state with enable high sets running in the next cycle, and pwm_out stays 0. The first tick after that begins the first period.
- R4: With enable high, pwm_out and cfg_err change only at a clock edge where tick is high. Each position of the pattern lasts from one tick to the next.
- R5: The ramp size is X = 8 + ramp_sel, so ramp_sel 0, 1, 2, 3 give X = 8, 9, 10, 11.
- R6: The rising ramp has X segments of X ticks each. In segment k (1..X), pwm_out is high for the first k ticks and low for the rest.
- R7: After the rising ramp there is one high pad tick. Then comes a high plateau of P = floor((period_len − 2·X² − 2)/2) ticks. For example, period_len 254 with X = 10 gives P = 26.
- R8: The falling ramp has X segments of X ticks. In segment k, pwm_out is high for the first X+1−k ticks. It is followed by one low pad tick and then a low plateau of period_len − 2·X² − 2 − P ticks, so one period lasts exactly period_len ticks.
- R9: period_len and ramp_sel are sampled only at the tick that begins a period. Changes in the middle of a period take effect at the next period.
- R10: If period_len < 2·X² + 2, both plateaus are 0 ticks long, the period lasts 2·X² + 2 ticks, and cfg_err is 1 from that period's first tick until the next period begins or enable drops.
- R11: A start pulse while running has no effect on the pattern.
- R12: While enable stays high, periods repeat back to back with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Base-unit tick, one cycle wide |
| enable | input | 1 | Runs the generator; low forces idle |
| start | input | 1 | Arms the generator from idle |
| period_len | input | PERIOD_W | Period length in ticks |
| ramp_sel | input | 2 | Ramp size select, X = 8 + ramp_sel |
| pwm_out | output | 1 | Pattern bit stream |
| running | output | 1 | High while armed or producing periods |
| cfg_err | output | 1 | Current period is too short for its ramps |

## Verification
The assertions assume that tick is a clean, synchronous single-cycle strobe and that start is only meaningful with enable high. They also assume that enable alone, and never a configuration change, can force the output between ticks. The stimulus drives every input at the falling edge. It keeps tick low for at least one cycle between pulses, and it changes period_len and ramp_sel only between ticks. This matches how the properties describe when pwm_out and cfg_err may move.

// File: rtl/slope_pkg.sv
package slope_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ARM,
      ST_RISE,
      ST_PADH,
      ST_TOP,
      ST_FALL,
      ST_PADL,
      ST_BOT
   } slope_st_e;

   localparam int unsigned RAMP_BASE = 8;
   localparam int unsigned XLEN_W    = 4;
   localparam int unsigned SQ_W      = 8;

   function automatic logic [XLEN_W-1:0] ramp_len(input logic [1:0] sel);
      return XLEN_W'(RAMP_BASE) + {2'b00, sel};
   endfunction

endpackage

// File: rtl/slope_plan.sv
module slope_plan
   import slope_pkg::*;
#(
   parameter int unsigned PERIOD_W = 10,
   parameter bit          SQ_LUT   = 1'b1
) (
   input  logic [PERIOD_W-1:0] period_len,
   input  logic [1:0]          ramp_sel,
   output logic [XLEN_W-1:0]   xlen,
   output logic [PERIOD_W-1:0] top_len,
   output logic [PERIOD_W-1:0] bot_len,
   output logic                short_err
);
   localparam int unsigned CW = PERIOD_W + 1;

   logic [SQ_W-1:0] sq;
   logic [CW-1:0]   ovh;
   logic [CW-1:0]   per_ext;
   logic [CW-1:0]   rem;

   assign xlen = ramp_len(ramp_sel);

   generate
      if (SQ_LUT) begin : g_sq_lut
         always_comb begin
            case (ramp_sel)
               2'd0:    sq = SQ_W'(64);
               2'd1:    sq = SQ_W'(81);
               2'd2:    sq = SQ_W'(100);
               default: sq = SQ_W'(121);
            endcase
         end
      end else begin : g_sq_mul
         logic [2*XLEN_W-1:0] prod;
         assign prod = {4'b0000, xlen} * {4'b0000, xlen};
         assign sq   = prod[SQ_W-1:0];
      end
   endgenerate

   assign ovh     = (CW'(sq) << 1) + CW'(2);
   assign per_ext = {1'b0, period_len};
   assign rem     = per_ext - ovh;

   always_comb begin
      if (per_ext < ovh) begin
         short_err = 1'b1;
         top_len   = '0;
         bot_len   = '0;
      end else begin
         short_err = 1'b0;
         top_len   = rem[PERIOD_W:1];
         bot_len   = rem[PERIOD_W-1:0] - rem[PERIOD_W:1];
      end
   end

endmodule

// File: rtl/slope_seq.sv
module slope_seq
   import slope_pkg::*;
#(
   parameter int unsigned PERIOD_W = 10
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick,
   input  logic                enable,
   input  logic                start,
   input  logic [XLEN_W-1:0]   xlen_in,
   input  logic [PERIOD_W-1:0] top_in,
   input  logic [PERIOD_W-1:0] bot_in,
   input  logic                err_in,
   output logic                pwm_out,
   output logic                running,
   output logic                cfg_err
);
   slope_st_e           st_q, st_n;
   logic [XLEN_W-1:0]   seg_q, seg_n;
   logic [XLEN_W-1:0]   pos_q, pos_n;
   logic [PERIOD_W-1:0] cnt_q, cnt_n;
   logic [XLEN_W-1:0]   x_q;
   logic [PERIOD_W-1:0] top_q, bot_q;
   logic                new_per;
   logic                out_n;
   logic                err_q;
   logic                out_q;
   logic [XLEN_W-1:0]   seg_one;

   assign seg_one = XLEN_W'(1);

   always_comb begin
      st_n    = st_q;
      seg_n   = seg_q;
      pos_n   = pos_q;
      cnt_n   = cnt_q;
      new_per = 1'b0;
      case (st_q)
         ST_ARM: new_per = 1'b1;
         ST_RISE, ST_FALL: begin
            if (pos_q == x_q - seg_one) begin
               pos_n = '0;
               if (seg_q == x_q) st_n = (st_q == ST_RISE) ? ST_PADH : ST_PADL;
               else              seg_n = seg_q + seg_one;
            end else begin
               pos_n = pos_q + seg_one;
            end
         end
         ST_PADH: begin
            cnt_n = '0;
            seg_n = seg_one;
            pos_n = '0;
            st_n  = (top_q != '0) ? ST_TOP : ST_FALL;
         end
         ST_TOP: begin
            if (cnt_q == top_q - PERIOD_W'(1)) begin
               st_n  = ST_FALL;
               seg_n = seg_one;
               pos_n = '0;
            end else begin
               cnt_n = cnt_q + PERIOD_W'(1);
            end
         end
         ST_PADL: begin
            cnt_n = '0;
            if (bot_q != '0) st_n = ST_BOT;
            else             new_per = 1'b1;
         end
         ST_BOT: begin
            if (cnt_q == bot_q - PERIOD_W'(1)) new_per = 1'b1;
            else                                 cnt_n = cnt_q + PERIOD_W'(1);
         end
         default: st_n = ST_IDLE;
      endcase
      if (new_per) begin
         st_n  = ST_RISE;
         seg_n = seg_one;
         pos_n = '0;
         cnt_n = '0;
      end
   end

   always_comb begin
      case (st_n)
         ST_RISE:         out_n = (pos_n < seg_n);
         ST_PADH, ST_TOP: out_n = 1'b1;
         ST_FALL:         out_n = (({1'b0, pos_n} + {1'b0, seg_n}) <= {1'b0, x_q});
         default:         out_n = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         seg_q <= '0;
         pos_q <= '0;
         cnt_q <= '0;
         x_q   <= '0;
         top_q <= '0;
         bot_q <= '0;
         err_q <= 1'b0;
         out_q <= 1'b0;
      end else if (!enable) begin
         st_q  <= ST_IDLE;
         err_q <= 1'b0;
         out_q <= 1'b0;
      end else if (st_q == ST_IDLE) begin
         if (start) st_q <= ST_ARM;
      end else if (tick) begin
         st_q  <= st_n;
         seg_q <= seg_n;
         pos_q <= pos_n;
         cnt_q <= cnt_n;
         out_q <= out_n;
         if (new_per) begin
            x_q   <= xlen_in;
            top_q <= top_in;
            bot_q <= bot_in;
            err_q <= err_in;
         end
      end
   end

   assign pwm_out = out_q;
   assign running = (st_q != ST_IDLE);
   assign cfg_err = err_q;

endmodule

// File: rtl/slope_pwm.sv
module slope_pwm
   import slope_pkg::*;
#(
   parameter int unsigned PERIOD_W = 10,
   parameter bit          SQ_LUT   = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick,
   input  logic                enable,
   input  logic                start,
   input  logic [PERIOD_W-1:0] period_len,
   input  logic [1:0]          ramp_sel,
   output logic                pwm_out,
   output logic                running,
   output logic                cfg_err
);
   localparam int unsigned MIN_W = 8;
   localparam int unsigned MAX_W = 16;

   initial begin
      assert (PERIOD_W >= MIN_W && PERIOD_W <= MAX_W)
         else $error("slope_pwm: PERIOD_W out of supported range");
   end

   logic [XLEN_W-1:0]   xlen;
   logic [PERIOD_W-1:0] top_len;
   logic [PERIOD_W-1:0] bot_len;
   logic                short_err;

   slope_plan #(
      .PERIOD_W (PERIOD_W),
      .SQ_LUT   (SQ_LUT)
   ) u_plan (
      .period_len (period_len),
      .ramp_sel   (ramp_sel),
      .xlen       (xlen),
      .top_len    (top_len),
      .bot_len    (bot_len),
      .short_err  (short_err)
   );

   slope_seq #(
      .PERIOD_W (PERIOD_W)
   ) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .enable  (enable),
      .start   (start),
      .xlen_in (xlen),
      .top_in  (top_len),
      .bot_in  (bot_len),
      .err_in  (short_err),
      .pwm_out (pwm_out),
      .running (running),
      .cfg_err (cfg_err)
   );

endmodule

// File: rtl/slope_pwm_chk.sv
module slope_pwm_chk (
   input logic clk,
   input logic rst_n,
   input logic tick,
   input logic enable,
   input logic start,
   input logic pwm_out,
   input logic running,
   input logic cfg_err
);
   // R2: a low enable forces the idle outputs one cycle later
   p_idle_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (!pwm_out && !running && !cfg_err));

   // R3: start from idle arms the generator
   p_start_arms_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && start && !running) |=> running);

   // R3: arming never raises the output by itself
   p_arm_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(running) |-> !pwm_out);

   // R4: no tick, no change of the pattern bit
   p_hold_between_ticks_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && !tick) |=> $stable(pwm_out));

   // R10: error flag only moves on a tick or a disable
   p_err_on_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && !tick) |=> $stable(cfg_err));

endmodule

bind slope_pwm slope_pwm_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .tick    (tick),
   .enable  (enable),
   .start   (start),
   .pwm_out (pwm_out),
   .running (running),
   .cfg_err (cfg_err)
);

// File: tb/slope_pwm_tb_top.sv
`timescale 1ns/1ps
module slope_pwm_tb_top;
   localparam int PW = 10;
   localparam int NV = 6;
   // period, ramp_sel, expected error, expected high ticks per period
   localparam int VEC [NV][4] = '{
      '{254, 2, 0, 137},
      '{200, 0, 0, 108},
      '{245, 1, 0, 131},
      '{244, 3, 0, 133},
      '{100, 3, 1, 133},
      '{131, 0, 0,  73}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick = 1'b0;
   logic          enable = 1'b0;
   logic          start = 1'b0;
   logic [PW-1:0] period_len = '0;
   logic [1:0]    ramp_sel = '0;
   logic          pwm_out, running, cfg_err;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   slope_pwm #(.PERIOD_W(PW)) dut_i (
      .clk(clk), .rst_n(rst_n), .tick(tick), .enable(enable), .start(start),
      .period_len(period_len), .ramp_sel(ramp_sel),
      .pwm_out(pwm_out), .running(running), .cfg_err(cfg_err)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int top_of(input int per, input int x);
      int ovh = 2*x*x + 2;
      return (per >= ovh) ? (per - ovh) / 2 : 0;
   endfunction

   function automatic int len_of(input int per, input int x);
      int ovh = 2*x*x + 2;
      return (per >= ovh) ? per : ovh;
   endfunction

   function automatic int exp_bit(input int per, input int x, input int i);
      int r = x*x;
      int t = top_of(per, x);
      int j;
      if (i < r) return ((i % x) < (i / x + 1)) ? 1 : 0;
      if (i < r + 1 + t) return 1;
      j = i - (r + 1 + t);
      if (j < r) return (((j % x) + (j / x + 1)) <= x) ? 1 : 0;
      return 0;
   endfunction

   task automatic one_tick;
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
   endtask

   task automatic arm(input int per, input int sel);
      @(negedge clk);
      enable = 1'b1;
      period_len = PW'(per);
      ramp_sel = 2'(sel);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
      chk("R3 running after start", int'(running), 1);
      chk("R3 output low while armed", int'(pwm_out), 0);
   endtask

   // steps cnt ticks from pattern index first, checks every bit, returns high count
   task automatic walk(input string req, input int per, input int x,
                       input int first, input int cnt, output int ones);
      int len = len_of(per, x);
      ones = 0;
      for (int k = 0; k < cnt; k++) begin
         one_tick();
         chk(req, int'(pwm_out), exp_bit(per, x, (first + k) % len));
         ones += int'(pwm_out);
      end
   endtask

   task automatic stop_run;
      @(negedge clk) enable = 1'b0;
      @(negedge clk);
      chk("R2 idle after disable", int'(running), 0);
      chk("R2 output low after disable", int'(pwm_out), 0);
      chk("R2 error cleared after disable", int'(cfg_err), 0);
   endtask

   initial begin
      int ones, x, len, held;
      chk("R1 reset pwm_out", int'(pwm_out), 0);
      chk("R1 reset running", int'(running), 0);
      chk("R1 reset cfg_err", int'(cfg_err), 0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R2: start while disabled is ignored
      start = 1'b1;
      @(negedge clk) start = 1'b0;
      @(negedge clk);
      chk("R2 start ignored when disabled", int'(running), 0);

      // table walk: R5 R6 R7 R8 R10 R12
      for (int v = 0; v < NV; v++) begin
         x = 8 + VEC[v][1];
         len = len_of(VEC[v][0], x);
         arm(VEC[v][0], VEC[v][1]);
         walk("R6 R7 R8 pattern bit", VEC[v][0], x, 0, len, ones);
         chk("R5 R7 R8 high ticks per period", ones, VEC[v][3]);
         chk("R10 error flag", int'(cfg_err), VEC[v][2]);
         walk("R12 second period bit", VEC[v][0], x, 0, len, ones);
         chk("R12 high ticks second period", ones, VEC[v][3]);
         stop_run();
      end

      // R11: start in mid run is ignored; R4: output held without tick
      arm(254, 2);
      walk("R11 pattern before start", 254, 10, 0, 50, ones);
      held = int'(pwm_out);
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      repeat (4) @(negedge clk);
      chk("R4 output held without tick", int'(pwm_out), held);
      walk("R11 pattern after start", 254, 10, 50, 204, ones);
      stop_run();

      // R9: mid-period reconfiguration applies at next period
      arm(200, 0);
      walk("R9 old period first half", 200, 8, 0, 100, ones);
      @(negedge clk);
      period_len = PW'(245);
      ramp_sel = 2'd1;
      walk("R9 old period second half", 200, 8, 100, 100, ones);
      walk("R9 new period pattern", 245, 9, 0, 245, ones);
      chk("R9 new period high ticks", ones, 131);

      // R10: short period raises error only from its own first tick
      @(negedge clk);
      period_len = PW'(100);
      ramp_sel = 2'd3;
      chk("R10 error not raised before period start", int'(cfg_err), 0);
      walk("R10 short period pattern", 100, 11, 0, 244, ones);
      chk("R10 error raised", int'(cfg_err), 1);
      stop_run();

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: got 0 expected 1 (run completed)");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule